// File: doc/BRIEF.md
# Per-Bit Clock-Gated Binary Counter

This block is a synchronous binary up-counter built to cut dynamic power. Each count bit is a toggle flop with its own gated clock. The gate is a behavioural OR of the free-running clock and an active-low gate enable, so a bit gets a rising clock edge only on cycles where it has to change. Bit 0 is opened on every counting cycle. A higher bit is opened only when every bit below it is 1. No shared next-state adder feeds D inputs: the toggle conditions alone produce the count sequence.

The count enable and the synchronous reset are first registered on the free-running clock. Every gate enable is then derived purely from registered state, so it changes only during the high phase of the clock, when the OR output is already held high. This keeps the gated clocks free of glitches. Because of that input register, a change on `run` or `rst` takes effect on the second rising edge after it is presented. A terminal-count flag marks the all-ones value, from which the next counting step wraps to zero. All pins are plain control and status signals, with no stream handshake. A bound checker carries an ungated reference counter and compares it with the gated counter on every cycle.

Top module: `clkgate_counter`

## Requirements
- R1: The width is a parameter N, legal from 2 to 16 with a default of 8, and `count` is N bits wide.
- R2: If `run` is 1 and `rst` is 0 when sampled at rising edge k, `count` is one greater (modulo 2^N) after edge k+1.
- R3: If `rst` is 1 when sampled at edge k, `count` is 0 after edge k+1, whatever `run` is.
- R4: If `run` and `rst` are both 0 when sampled at edge k, `count` is unchanged after edge k+1.
- R5: A counting step from the all-ones value gives 0.
- R6: `tc` is 1 exactly when every bit of `count` is 1.
- R7: A bit's gated clock is opened only on cycles where that bit changes. Bit 0 is opened on every counting cycle. Bit i is opened only when all lower bits are 1. During a clear, every bit is opened.
- R8: Each gate enable keeps one value through the whole low phase of the clock, so `count` moves only at rising edges of the clock.
- R9: The gated count equals an ungated registered reference counter, driven by the same registered controls, on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; rising edge active |
| rst | input | 1 | Active-high synchronous clear, registered before use |
| run | input | 1 | Count enable, registered before use |
| count | output | N | Current count value |
| tc | output | 1 | High when count is all ones |

## Verification
The bench builds two instances side by side. One uses the default N=8, so full wraps through 255 and carry ripples across all eight gates can be seen. The other uses N=2, which wraps every four counting steps, so the terminal-count and wrap paths are crossed many times under random enable and clear traffic. Both instances see the same stimulus, and their results are checked against width-aware bench functions, including a clear that lands while `run` is held high.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
  localparam int unsigned CGC_MIN_W = 2;
  localparam int unsigned CGC_MAX_W = 16;

  typedef enum logic [1:0] {
    CGC_HOLD  = 2'd0,
    CGC_STEP  = 2'd1,
    CGC_CLEAR = 2'd2
  } cgc_action_e;
endpackage

// File: rtl/cgc_input_stage.sv
module cgc_input_stage (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic clr_q,
  output logic run_q
);
  always_ff @(posedge clk) begin
    clr_q <= rst;
    run_q <= run & ~rst;
  end
endmodule

// File: rtl/cgc_enable_logic.sv
module cgc_enable_logic #(
  parameter int unsigned N = 8
) (
  input  logic         clr_q,
  input  logic         run_q,
  input  logic [N-1:0] count,
  output logic [N-1:0] gate_open
);
  logic [N-1:0] below_ones;

  assign below_ones[0] = 1'b1;
  for (genvar i = 1; i < N; i++) begin : g_chain
    assign below_ones[i] = below_ones[i-1] & count[i-1];
  end

  for (genvar i = 0; i < N; i++) begin : g_open
    assign gate_open[i] = clr_q | (run_q & below_ones[i]);
  end
endmodule

// File: rtl/cgc_clock_gate.sv
module cgc_clock_gate (
  input  logic clk,
  input  logic en_n,
  output logic gclk
);
  assign gclk = clk | en_n;
endmodule

// File: rtl/cgc_toggle_bit.sv
module cgc_toggle_bit (
  input  logic gclk,
  input  logic clr,
  output logic q
);
  always_ff @(posedge gclk) begin
    if (clr) q <= 1'b0;
    else     q <= ~q;
  end
endmodule

// File: rtl/clkgate_counter.sv
module clkgate_counter #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  output logic [N-1:0] count,
  output logic         tc
);
  import cgc_pkg::*;

  if (N < CGC_MIN_W || N > CGC_MAX_W) begin : g_bad_width
    $error("clkgate_counter: N out of range");
  end

  logic         clr_q;
  logic         run_q;
  logic [N-1:0] gate_open;
  logic [N-1:0] gclk;

  cgc_input_stage u_in (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clr_q (clr_q),
    .run_q (run_q)
  );

  cgc_enable_logic #(.N(N)) u_en (
    .clr_q     (clr_q),
    .run_q     (run_q),
    .count     (count),
    .gate_open (gate_open)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    cgc_clock_gate u_gate (
      .clk  (clk),
      .en_n (~gate_open[i]),
      .gclk (gclk[i])
    );
    cgc_toggle_bit u_tff (
      .gclk (gclk[i]),
      .clr  (clr_q),
      .q    (count[i])
    );
  end

  assign tc = &count;
endmodule

// File: rtl/clkgate_counter_chk.sv
module clkgate_counter_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         clr_q,
  input logic         run_q,
  input logic [N-1:0] gate_open,
  input logic [N-1:0] count,
  input logic         tc
);
  logic         primed;
  logic [N-1:0] ref_cnt;
  logic [N-1:0] open_at_fall;

  always_ff @(posedge clk) begin
    if (rst)        primed <= 1'b0;
    else if (clr_q) primed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr_q)      ref_cnt <= '0;
    else if (run_q) ref_cnt <= ref_cnt + 1'b1;
  end

  always_ff @(negedge clk) open_at_fall <= gate_open;

  // R9: gated count tracks the ungated reference
  p_match_ref_r9: assert property (@(posedge clk) disable iff (rst)
    primed |-> count == ref_cnt);

  // R3: clear lands on the next edge
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> count == '0);

  // R2: step by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (primed && run_q && !clr_q) |=> count == $past(count) + 1'b1);

  // R4: hold when idle
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (primed && !run_q && !clr_q) |=> $stable(count));

  // R5: wrap from all ones
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && tc && run_q && !clr_q) |=> count == '0);

  // R6: flag follows the all-ones value
  p_tc_r6: assert property (@(posedge clk) disable iff (rst)
    primed |-> tc == ($countones(count) == N));

  // R7: bit 0 is opened on every counting cycle
  p_bit0_open_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q || clr_q) |-> gate_open[0]);

  for (genvar i = 0; i < N; i++) begin : g_bitchk
    // R7: an opened gate during counting changes its bit
    p_open_moves_r7: assert property (@(posedge clk) disable iff (rst)
      (primed && gate_open[i] && !clr_q) |=> count[i] != $past(count[i]));
    // R7: a closed gate leaves its bit alone
    p_closed_holds_r7: assert property (@(posedge clk) disable iff (rst)
      (primed && !gate_open[i]) |=> $stable(count[i]));
    // R8: enable unchanged since the falling edge
    p_stable_low_r8: assert property (@(posedge clk) disable iff (rst)
      primed |-> gate_open[i] == open_at_fall[i]);
  end
endmodule

bind clkgate_counter clkgate_counter_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr_q     (clr_q),
  .run_q     (run_q),
  .gate_open (gate_open),
  .count     (count),
  .tc        (tc)
);

// File: tb/test_clkgate_counter.sv
`timescale 1ns/1ps
module test_clkgate_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic [7:0] cnt8;
  logic       tc8;
  logic [1:0] cnt2;
  logic       tc2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  clkgate_counter #(.N(8)) i_clkgate_counter (
    .clk(clk), .rst(rst), .run(run), .count(cnt8), .tc(tc8));
  clkgate_counter #(.N(2)) i_clkgate_counter_n2 (
    .clk(clk), .rst(rst), .run(run), .count(cnt2), .tc(tc2));

  function automatic logic [15:0] bump(input logic [15:0] v, input int w);
    logic [15:0] mask;
    mask = 16'((32'd1 << w) - 1);
    return (v + 16'd1) & mask;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model: inputs pass one register, then act on the next edge
  logic [15:0] m8 = '0, m2 = '0, p8 = '0, p2 = '0;
  bit m_clr = 1'b0, m_run = 1'b0, model_ok = 1'b0;
  int act = 0;

  always @(posedge clk) begin
    p8 = m8;
    p2 = m2;
    if (m_clr) begin
      m8 = '0; m2 = '0; model_ok = 1'b1; act = 2;
    end else if (m_run) begin
      m8 = bump(m8, 8); m2 = bump(m2, 2); act = 1;
    end else begin
      act = 0;
    end
    m_clr = rst;
    m_run = run & ~rst;
  end

  function automatic string tag_for(input int a, input logic [15:0] prev,
                                    input logic [15:0] top);
    if (a == 2) return "R3";
    if (a == 1) return (prev == top) ? "R5" : "R2";
    return "R4";
  endfunction

  always @(negedge clk) begin
    if (model_ok && !done) begin
      logic [7:0] s8;
      chk(cnt8 == m8[7:0], {tag_for(act, p8, 16'hff), " R9 n8"}, 16'(cnt8), m8);
      chk(cnt2 == m2[1:0], {tag_for(act, p2, 16'h3), " R9 n2"}, 16'(cnt2), m2);
      chk(tc8 == (m8[7:0] == 8'hff), "R6 n8", 16'(tc8), 16'(m8[7:0] == 8'hff));
      chk(tc2 == (m2[1:0] == 2'h3), "R6 n2", 16'(tc2), 16'(m2[1:0] == 2'h3));
      if (act == 1)
        chk((cnt8 ^ p8[7:0]) == (p8[7:0] ^ bump(p8, 8)), "R7 changed bits n8",
            16'(cnt8 ^ p8[7:0]), p8 ^ bump(p8, 8));
      s8 = cnt8;
      #2.2;
      chk(cnt8 == s8, "R8 no move in low phase", 16'(cnt8), 16'(s8));
    end
  end

  task automatic step(input bit r, input bit e);
    @(posedge clk);
    #1;
    rst = r;
    run = e;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    chk($bits(cnt8) == 8, "R1 width n8", 16'($bits(cnt8)), 16'd8);
    chk($bits(cnt2) == 2, "R1 width n2", 16'($bits(cnt2)), 16'd2);
    repeat (3) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    // reset state
    chk(cnt8 == 8'h00 && tc8 == 1'b0, "R3 reset state", 16'(cnt8), 16'h0);
    repeat (5) step(1'b0, 1'b0);                 // R4 hold at zero
    repeat (300) step(1'b0, 1'b1);               // R2, R5, R6 full wrap
    repeat (4) step(1'b0, 1'b0);                 // R4 hold mid-count
    repeat (2) step(1'b1, 1'b1);                 // R3 clear beats run
    step(1'b0, 1'b1);
    @(negedge clk);
    chk(cnt8 == 8'h00, "R3 clear priority", 16'(cnt8), 16'h0);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 60) == 0, ($urandom % 4) != 0);
    repeat (3) step(1'b0, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule